// File: doc/BRIEF.md
# 8-bit Accumulator Execute Unit with Register-Pair Arithmetic

This block is the execute stage of a small 8-bit accumulator machine. Each cycle that the execute strobe is high, it takes an operation code, an operand (a file-register byte or an 8-bit literal), the held accumulator and the held carry. On that clock edge it updates the accumulator, the carry, digit-carry and zero flags, and a one-cycle write-back strobe with the byte (and possibly a high byte) that the file register receives. Fetch, sequencing, the register file storage and any stack are outside the block. The surrounding core provides the indexed register byte and the byte at the index one below it, and stores whatever the write-back outputs carry.

Operation codes on `op`: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 complement, 9 clear, 10 nibble swap, 11 rotate left through carry, 12 rotate right through carry. Codes 13 to 15 change nothing. Subtraction always computes operand minus accumulator. For the immediate form this means the literal minus the accumulator.

When arithmetic targets one of five odd register indices, it runs on a 16-bit pair. The low byte of the pair sits at that index and the high byte at the index below it.

Top module: `alu8_pair_exec`

## Requirements
- R1: While `rst_n` is low and after it is released, `acc` is 0x00, all three flags are 0, and `wb_file` and `wb_pair` are 0.
- R2: Add (op 0) stores accumulator plus operand. Add with carry (op 1) also adds the held carry. Carry becomes the carry out of bit 7 and zero is set when the 8-bit result is 0x00.
- R3: For every add and subtract form, digit carry is the carry out of the low four bits, with the carry or borrow input included. For subtraction it is the inverse of the low-nibble borrow.
- R4: Subtract (op 2) stores operand minus accumulator. Subtract with borrow (op 3) also subtracts the inverse of the held carry. Carry becomes the inverse of the borrow out of bit 7.
- R5: Compare (op 4) sets carry and digit carry as subtract does, and sets zero exactly when operand equals accumulator. It writes neither the accumulator nor a file register.
- R6: When `to_file` is 1, `use_imm` is 0, `reg_idx` is 5, 7, 9, 13 or 17, and op is 0 to 3, the operation runs on the 16-bit value {`file_hi`,`file_lo`}. `wb_pair` pulses with `wb_hi` holding the new high byte. Zero and `wb_lo` reflect only the low byte, and carry and digit carry come from the 8-bit operands.
- R7: AND, OR, XOR (ops 5 to 7, with the accumulator), complement and clear (ops 8, 9) update only the zero flag. Clear always yields 0x00 with zero set.
- R8: Rotate left (op 11) moves bit 7 into carry and the old carry into bit 0. Rotate right (op 12) moves bit 0 into carry and the old carry into bit 7. Digit carry and zero are unchanged.
- R9: Nibble swap (op 10) exchanges the two halves of the operand and leaves all three flags unchanged.
- R10: With `to_file` 0, the result goes to `acc`. With `to_file` 1, it goes out on `wb_lo` with a one-cycle `wb_file` pulse, and `acc` is kept. A literal operand (`use_imm` 1) always targets the accumulator.
- R11: With `exec_en` low, the accumulator and flags hold and no write-back strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_en | input | 1 | Execute strobe; state updates on this edge |
| op | input | 4 | Operation code |
| to_file | input | 1 | Destination: 0 accumulator, 1 file register |
| use_imm | input | 1 | Take operand from `imm` instead of `file_lo` |
| reg_idx | input | 5 | File register index (selects pair mode) |
| file_lo | input | 8 | Byte at `reg_idx` |
| file_hi | input | 8 | Byte at `reg_idx` minus one |
| imm | input | 8 | Literal operand |
| acc | output | 8 | Accumulator |
| c_flag | output | 1 | Carry (inverse borrow after subtraction) |
| dc_flag | output | 1 | Digit carry |
| z_flag | output | 1 | Zero |
| wb_file | output | 1 | One-cycle file-register write strobe |
| wb_pair | output | 1 | High byte of the pair is also written |
| wb_lo | output | 8 | Byte written to the indexed register |
| wb_hi | output | 8 | Byte written to the register one below |

## Verification
The arithmetic cases use operand pairs that separate the carry out of bit 7 from the carry out of bit 3, including a case where only the incoming carry pushes a nibble over. This distinguishes a digit carry computed with the carry input from one computed without it. Subtraction uses an operand smaller than the accumulator as well as one larger, and the borrowing form is run with each held carry value. Swapped operands or a non-inverted borrow then show up as a wrong difference or a wrong flag. Pair-mode cases use each of the five indices, neighbouring non-pair indices, and the accumulator destination. They include low-byte overflow into the high byte, underflow out of it, and a zero low byte with a nonzero high byte, so the zero flag is seen to follow the low byte alone. The logic, rotate and swap cases start from a known preset of flags, so any flag that should hold can be told apart from one that was rewritten.

// File: rtl/alu8_pair_exec.sv
module alu8_pair_exec #(
  parameter int W    = 8,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exec_en,
  input  logic [3:0]      op,
  input  logic            to_file,
  input  logic            use_imm,
  input  logic [IDXW-1:0] reg_idx,
  input  logic [W-1:0]    file_lo,
  input  logic [W-1:0]    file_hi,
  input  logic [W-1:0]    imm,
  output logic [W-1:0]    acc,
  output logic            c_flag,
  output logic            dc_flag,
  output logic            z_flag,
  output logic            wb_file,
  output logic            wb_pair,
  output logic [W-1:0]    wb_lo,
  output logic [W-1:0]    wb_hi
);
  localparam int H = W / 2;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDC = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_SUBB = 4'd3;
  localparam logic [3:0] OP_CMP  = 4'd4;
  localparam logic [3:0] OP_AND  = 4'd5;
  localparam logic [3:0] OP_OR   = 4'd6;
  localparam logic [3:0] OP_XOR  = 4'd7;
  localparam logic [3:0] OP_NOT  = 4'd8;
  localparam logic [3:0] OP_CLR  = 4'd9;
  localparam logic [3:0] OP_SWAP = 4'd10;
  localparam logic [3:0] OP_RL   = 4'd11;
  localparam logic [3:0] OP_RR   = 4'd12;

  logic [W-1:0] opnd;
  logic         dst_file;
  logic         is_add, is_sub, is_arith;
  logic         cin, bin;
  logic [W:0]   sum, diff;
  logic [H:0]   nsum, ndiff;
  logic         pair_idx, pair_op;
  logic [W-1:0] hi_next;

  logic [W-1:0] res;
  logic         c_n, dc_n, z_n;
  logic         writes;

  assign opnd     = use_imm ? imm : file_lo;
  assign dst_file = to_file & ~use_imm;

  assign is_add   = (op == OP_ADD) || (op == OP_ADDC);
  assign is_sub   = (op == OP_SUB) || (op == OP_SUBB) || (op == OP_CMP);
  assign is_arith = is_add || (op == OP_SUB) || (op == OP_SUBB);

  assign cin = (op == OP_ADDC) & c_flag;
  assign bin = (op == OP_SUBB) & ~c_flag;

  assign sum   = {1'b0, acc} + {1'b0, opnd} + {{W{1'b0}}, cin};
  assign nsum  = {1'b0, acc[H-1:0]} + {1'b0, opnd[H-1:0]} + {{H{1'b0}}, cin};
  assign diff  = {1'b0, opnd} - {1'b0, acc} - {{W{1'b0}}, bin};
  assign ndiff = {1'b0, opnd[H-1:0]} - {1'b0, acc[H-1:0]} - {{H{1'b0}}, bin};

  assign pair_idx = (reg_idx == IDXW'(5))  || (reg_idx == IDXW'(7)) ||
                    (reg_idx == IDXW'(9))  || (reg_idx == IDXW'(13)) ||
                    (reg_idx == IDXW'(17));
  assign pair_op  = dst_file & pair_idx & is_arith;
  assign hi_next  = is_add ? file_hi + {{(W-1){1'b0}}, sum[W]}
                           : file_hi - {{(W-1){1'b0}}, diff[W]};

  assign writes = (op <= OP_RR) && (op != OP_CMP);

  always_comb begin
    res  = opnd;
    c_n  = c_flag;
    dc_n = dc_flag;
    z_n  = z_flag;
    unique case (op)
      OP_ADD, OP_ADDC: begin
        res  = sum[W-1:0];
        c_n  = sum[W];
        dc_n = nsum[H];
        z_n  = (sum[W-1:0] == '0);
      end
      OP_SUB, OP_SUBB, OP_CMP: begin
        res  = diff[W-1:0];
        c_n  = ~diff[W];
        dc_n = ~ndiff[H];
        z_n  = (diff[W-1:0] == '0);
      end
      OP_AND: begin res = acc & opnd; z_n = (res == '0); end
      OP_OR:  begin res = acc | opnd; z_n = (res == '0); end
      OP_XOR: begin res = acc ^ opnd; z_n = (res == '0); end
      OP_NOT: begin res = ~opnd;      z_n = (res == '0); end
      OP_CLR: begin res = '0;         z_n = 1'b1;        end
      OP_SWAP: res = {opnd[H-1:0], opnd[W-1:H]};
      OP_RL: begin
        res = {opnd[W-2:0], c_flag};
        c_n = opnd[W-1];
      end
      OP_RR: begin
        res = {c_flag, opnd[W-1:1]};
        c_n = opnd[0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      c_flag  <= 1'b0;
      dc_flag <= 1'b0;
      z_flag  <= 1'b0;
      wb_file <= 1'b0;
      wb_pair <= 1'b0;
      wb_lo   <= '0;
      wb_hi   <= '0;
    end else begin
      wb_file <= exec_en & writes & dst_file;
      wb_pair <= exec_en & pair_op;
      if (exec_en) begin
        c_flag  <= c_n;
        dc_flag <= dc_n;
        z_flag  <= z_n;
        wb_lo   <= res;
        if (pair_op) wb_hi <= hi_next;
        if (writes && !dst_file) acc <= res;
      end
    end
  end
endmodule

// File: rtl/alu8_pair_exec_chk.sv
module alu8_pair_exec_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         exec_en,
  input logic [3:0]   op,
  input logic         use_imm,
  input logic [W-1:0] acc,
  input logic         c_flag,
  input logic         dc_flag,
  input logic         z_flag,
  input logic         wb_file,
  input logic         wb_pair
);
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable(acc) && $stable(c_flag) && $stable(dc_flag) && $stable(z_flag) && !wb_file && !wb_pair);

  p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op == 4'd4 |=> !wb_file && $stable(acc));

  p_logic_keep_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op inside {[4'd5:4'd9]} |=> $stable(c_flag) && $stable(dc_flag));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op == 4'd9 |=> z_flag);

  p_swap_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op == 4'd10 |=> $stable(c_flag) && $stable(dc_flag) && $stable(z_flag));

  p_rotate_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && (op == 4'd11 || op == 4'd12) |=> $stable(dc_flag) && $stable(z_flag));

  p_imm_to_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && use_imm |=> !wb_file && !wb_pair);

  p_pair_is_file_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pair |-> wb_file);
endmodule

bind alu8_pair_exec alu8_pair_exec_chk #(.W(W)) u_chk (.*);

// File: tb/sim_alu8_pair_exec.sv
module sim_alu8_pair_exec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_en = 1'b0;
  logic [3:0] op = '0;
  logic       to_file = 1'b0, use_imm = 1'b0;
  logic [4:0] reg_idx = '0;
  logic [7:0] file_lo = '0, file_hi = '0, imm = '0;
  logic [7:0] acc, wb_lo, wb_hi;
  logic       c_flag, dc_flag, z_flag, wb_file, wb_pair;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu8_pair_exec u0 (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op(op), .to_file(to_file),
    .use_imm(use_imm), .reg_idx(reg_idx), .file_lo(file_lo), .file_hi(file_hi),
    .imm(imm), .acc(acc), .c_flag(c_flag), .dc_flag(dc_flag), .z_flag(z_flag),
    .wb_file(wb_file), .wb_pair(wb_pair), .wb_lo(wb_lo), .wb_hi(wb_hi)
  );

  typedef struct packed {
    logic [3:0] op;
    logic       dst;
    logic       im;
    logic [4:0] idx;
    logic [7:0] flo, fhi, imm, a;
    logic       cin;
    logic [7:0] e_acc;
    logic       e_c, e_dc, e_z, e_we, e_pr;
    logic [7:0] e_lo, e_hi;
  } vec_t;

  // preset before each vector: acc = a, carry = cin, digit carry = 1, zero = (a == 0)
  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    '{4'd0, 1'b0,1'b0,5'd2,  8'h3A,8'h00,8'h00,8'h28,1'b0, 8'h62, 1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00,8'h00},
    '{4'd0, 1'b0,1'b1,5'd0,  8'h00,8'h00,8'hFF,8'h01,1'b0, 8'h00, 1'b1,1'b1,1'b1,1'b0,1'b0, 8'h00,8'h00},
    '{4'd1, 1'b1,1'b0,5'd3,  8'h10,8'h00,8'h00,8'h0F,1'b1, 8'h0F, 1'b0,1'b1,1'b0,1'b1,1'b0, 8'h20,8'h00},
    '{4'd1, 1'b0,1'b0,5'd3,  8'h10,8'h00,8'h00,8'h0F,1'b0, 8'h1F, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00},
    '{4'd2, 1'b0,1'b0,5'd2,  8'h50,8'h00,8'h00,8'h20,1'b0, 8'h30, 1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00,8'h00},
    '{4'd2, 1'b0,1'b0,5'd2,  8'h05,8'h00,8'h00,8'h06,1'b1, 8'hFF, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00},
    '{4'd3, 1'b0,1'b1,5'd0,  8'h00,8'h00,8'h10,8'h0F,1'b0, 8'h00, 1'b1,1'b0,1'b1,1'b0,1'b0, 8'h00,8'h00},
    '{4'd3, 1'b0,1'b0,5'd2,  8'h10,8'h00,8'h00,8'h0F,1'b1, 8'h01, 1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00},
    '{4'd4, 1'b0,1'b1,5'd0,  8'h00,8'h00,8'h42,8'h42,1'b0, 8'h42, 1'b1,1'b1,1'b1,1'b0,1'b0, 8'h00,8'h00},
    '{4'd4, 1'b0,1'b0,5'd2,  8'h10,8'h00,8'h00,8'h20,1'b1, 8'h20, 1'b0,1'b1,1'b0,1'b0,1'b0, 8'h00,8'h00},
    '{4'd0, 1'b1,1'b0,5'd5,  8'hF0,8'h12,8'h00,8'h20,1'b0, 8'h20, 1'b1,1'b0,1'b0,1'b1,1'b1, 8'h10,8'h13},
    '{4'd2, 1'b1,1'b0,5'd13, 8'h00,8'h01,8'h00,8'h01,1'b0, 8'h01, 1'b0,1'b0,1'b0,1'b1,1'b1, 8'hFF,8'h00},
    '{4'd0, 1'b1,1'b0,5'd17, 8'hFF,8'h00,8'h00,8'h01,1'b0, 8'h01, 1'b1,1'b1,1'b1,1'b1,1'b1, 8'h00,8'h01},
    '{4'd3, 1'b1,1'b0,5'd9,  8'h34,8'h12,8'h00,8'h34,1'b1, 8'h34, 1'b1,1'b1,1'b1,1'b1,1'b1, 8'h00,8'h12},
    '{4'd1, 1'b1,1'b0,5'd7,  8'hFE,8'hFF,8'h00,8'h01,1'b1, 8'h01, 1'b1,1'b1,1'b1,1'b1,1'b1, 8'h00,8'h00},
    '{4'd0, 1'b1,1'b0,5'd4,  8'hF0,8'h12,8'h00,8'h20,1'b0, 8'h20, 1'b1,1'b0,1'b0,1'b1,1'b0, 8'h10,8'h00},
    '{4'd0, 1'b0,1'b0,5'd5,  8'hF0,8'h12,8'h00,8'h20,1'b0, 8'h10, 1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00},
    '{4'd5, 1'b0,1'b1,5'd0,  8'h00,8'h00,8'h0F,8'hF0,1'b1, 8'h00, 1'b1,1'b1,1'b1,1'b0,1'b0, 8'h00,8'h00},
    '{4'd6, 1'b1,1'b0,5'd2,  8'h0C,8'h00,8'h00,8'h30,1'b0, 8'h30, 1'b0,1'b1,1'b0,1'b1,1'b0, 8'h3C,8'h00},
    '{4'd7, 1'b0,1'b0,5'd2,  8'hAA,8'h00,8'h00,8'hAA,1'b1, 8'h00, 1'b1,1'b1,1'b1,1'b0,1'b0, 8'h00,8'h00},
    '{4'd8, 1'b1,1'b0,5'd2,  8'hFF,8'h00,8'h00,8'h11,1'b0, 8'h11, 1'b0,1'b1,1'b1,1'b1,1'b0, 8'h00,8'h00},
    '{4'd9, 1'b1,1'b0,5'd2,  8'h77,8'h00,8'h00,8'h05,1'b1, 8'h05, 1'b1,1'b1,1'b1,1'b1,1'b0, 8'h00,8'h00},
    '{4'd10,1'b0,1'b0,5'd2,  8'h3C,8'h00,8'h00,8'h00,1'b1, 8'hC3, 1'b1,1'b1,1'b1,1'b0,1'b0, 8'h00,8'h00},
    '{4'd10,1'b1,1'b0,5'd2,  8'hA5,8'h00,8'h00,8'h07,1'b0, 8'h07, 1'b0,1'b1,1'b0,1'b1,1'b0, 8'h5A,8'h00},
    '{4'd11,1'b0,1'b0,5'd2,  8'h81,8'h00,8'h00,8'h00,1'b0, 8'h02, 1'b1,1'b1,1'b1,1'b0,1'b0, 8'h00,8'h00},
    '{4'd11,1'b1,1'b0,5'd2,  8'h40,8'h00,8'h00,8'h09,1'b1, 8'h09, 1'b0,1'b1,1'b0,1'b1,1'b0, 8'h81,8'h00},
    '{4'd12,1'b0,1'b0,5'd2,  8'h01,8'h00,8'h00,8'h33,1'b1, 8'h80, 1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00,8'h00},
    '{4'd12,1'b1,1'b0,5'd2,  8'h02,8'h00,8'h00,8'h00,1'b0, 8'h00, 1'b0,1'b1,1'b1,1'b1,1'b0, 8'h01,8'h00},
    '{4'd2, 1'b0,1'b1,5'd0,  8'h00,8'h00,8'h05,8'h03,1'b0, 8'h02, 1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00,8'h00},
    '{4'd0, 1'b1,1'b1,5'd0,  8'h00,8'h00,8'h01,8'h01,1'b0, 8'h02, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00}
  };

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'd0, 4'd1:          return "R2";
      4'd2, 4'd3:          return "R4";
      4'd4:                return "R5";
      4'd5, 4'd6, 4'd7,
      4'd8, 4'd9:          return "R7";
      4'd10:               return "R9";
      default:             return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] o, input logic d, input logic i, input logic [4:0] x,
                      input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] k);
    @(negedge clk);
    op = o; to_file = d; use_imm = i; reg_idx = x; file_lo = lo; file_hi = hi; imm = k;
    exec_en = 1'b1;
    @(negedge clk);
    exec_en = 1'b0;
  endtask

  task automatic preset(input logic [7:0] a, input logic c);
    step(4'd9,  1'b0, 1'b0, 5'd2, 8'h00, 8'h00, 8'h00);
    step(4'd4,  1'b0, 1'b1, 5'd0, 8'h00, 8'h00, 8'h00);
    step(4'd11, 1'b1, 1'b0, 5'd2, c ? 8'h80 : 8'h00, 8'h00, 8'h00);
    step(4'd6,  1'b0, 1'b1, 5'd0, 8'h00, 8'h00, a);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "acc", acc, 8'h00);
    chk("R1", "flags", {5'b0, c_flag, dc_flag, z_flag}, 8'h00);
    chk("R1", "strobes", {6'b0, wb_file, wb_pair}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "acc after release", acc, 8'h00);

    for (int n = 0; n < NV; n++) begin
      vec_t v = TBL[n];
      string t = tag(v.op);
      preset(v.a, v.cin);
      step(v.op, v.dst, v.im, v.idx, v.flo, v.fhi, v.imm);
      chk(t, $sformatf("v%0d acc", n), acc, v.e_acc);
      chk(t, $sformatf("v%0d carry", n), {7'b0, c_flag}, {7'b0, v.e_c});
      chk((v.op <= 4'd4) ? "R3" : t, $sformatf("v%0d digit carry", n), {7'b0, dc_flag}, {7'b0, v.e_dc});
      chk(t, $sformatf("v%0d zero", n), {7'b0, z_flag}, {7'b0, v.e_z});
      chk("R10", $sformatf("v%0d file write", n), {7'b0, wb_file}, {7'b0, v.e_we});
      chk("R6", $sformatf("v%0d pair write", n), {7'b0, wb_pair}, {7'b0, v.e_pr});
      if (v.e_we) chk("R10", $sformatf("v%0d low byte", n), wb_lo, v.e_lo);
      if (v.e_pr) chk("R6", $sformatf("v%0d high byte", n), wb_hi, v.e_hi);
    end

    // R11: add presented with exec_en low changes nothing
    preset(8'h44, 1'b1);
    @(negedge clk);
    op = 4'd0; to_file = 1'b1; use_imm = 1'b0; reg_idx = 5'd5; file_lo = 8'hFF; file_hi = 8'h00;
    exec_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11", "acc held", acc, 8'h44);
    chk("R11", "flags held", {5'b0, c_flag, dc_flag, z_flag}, 8'b0000_0110);
    chk("R11", "no strobe", {6'b0, wb_file, wb_pair}, 8'h00);

    // R1: reset in mid-run clears state again
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "acc after second reset", acc, 8'h00);
    chk("R1", "flags after second reset", {5'b0, c_flag, dc_flag, z_flag}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule